// File: doc/BRIEF.md
# Region Protection Register File

This block holds the software-visible configuration of a region-based memory protection unit. It has a read-only geometry word, a three-bit control word, a pointer to the current region, and a base word and an attribute/size word for each region. The number of regions is a parameter, from 1 to 16. The address checker that uses these values is a separate block. This block only stores the values, returns them on reads, and tells the checker when they change.

Software reaches the regions in two ways. It can set the region pointer and then access the base or attribute word. It can also write a base word with its select bit set, which names the region in the same write and moves the pointer to it. The base and attribute pair also appears at three more word pairs, so a driver can program several regions in a row without rewriting the pointer. Any accepted change to the control, base or attribute state raises a single-cycle invalidate pulse. A translation cache downstream uses that pulse to discard its entries.

The register port is a single word-indexed access. Writes take effect at the clock edge. Reads are combinational from the word index and the current state.

Top module: `mpu_reg_file`

## Requirements
- R1: Word 0 (geometry) reads the region count shifted left by 8. Writes to it change nothing and raise no invalidate.
- R2: Word 1 (control) stores only write-data bits [2:0]: bit 0 enable, bit 1 keep-active-in-fault, bit 2 default-map-for-privileged. Bits [31:3] read as zero.
- R3: A control write with bit 1 set and bit 0 clear pulses `ctrl_illegal` high for the cycle after the write. The value is still stored.
- R4: Word 2 (region pointer) stores a written value below the region count. A value at or above the count is ignored. It reads back in bits [3:0] with zeros above.
- R5: A base write with bit 4 clear stores data bits [31:5] into the region named by the pointer. A base read returns stored bits [31:5], zero in bit 4 and the pointer in bits [3:0].
- R6: A base write with bit 4 set takes the region from data bits [3:0]. If that region is below the count, the base is stored there and the pointer is set to it. Otherwise the write has no effect at all: no store, no pointer change and no invalidate.
- R7: An attribute write stores data[15:0] AND 0xFF3F as the size/enable half and data[31:16] AND 0x173F as the attribute half, both for the region named by the pointer. A read returns the attribute half in [31:16] and the size half in [15:0].
- R8: The base word is found at word indices 3, 5, 7 and 9, and the attribute word at 4, 6, 8 and 10. All four copies of each reach the same storage.
- R9: Every accepted write to the control, base or attribute words drives `inval` high for exactly the cycle after the write. Nothing else drives it high.
- R10: After reset the control word, the pointer and every region's base and attribute state are zero, and `inval` and `ctrl_illegal` are low.
- R11: Word indices 11 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| wr_en | input | 1 | Write strobe for the word at reg_idx |
| reg_idx | input | 4 | Word index of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the word at reg_idx (combinational) |
| inval | output | 1 | One-cycle pulse after an accepted protection-state change |
| ctrl_illegal | output | 1 | One-cycle pulse after a control write with bit 1 set and bit 0 clear |

## Verification
A base write with the select bit set does two things in one cycle: it updates the pointer register and it stores into a region that the current pointer does not name. After every such write the bench reads the base word back. The low nibble must show the new pointer, and the upper bits must show the base of that region, not of the old one. Out-of-range selects are mixed into the same sweep, and after each one the pointer, the stored bases and the invalidate line must all be unchanged. An illegal control value likewise raises both pulses in the same cycle. The bench checks the two pulses together and then reads the stored value back.

// File: rtl/mpu_regs_pkg.sv
package mpu_regs_pkg;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_GEOM = 3'd1,
    K_CTRL = 3'd2,
    K_PTR  = 3'd3,
    K_BASE = 3'd4,
    K_ATTR = 3'd5
  } reg_kind_e;

  localparam int unsigned IDX_W    = 4;   // region field width in the base word
  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned BASE_LSB = 5;
  localparam int unsigned SEL_BIT  = 4;
  localparam logic [15:0] SIZE_MASK = 16'hFF3F;
  localparam logic [15:0] ATTR_MASK = 16'h173F;

  // word index layout
  localparam int unsigned W_GEOM  = 0;
  localparam int unsigned W_CTRL  = 1;
  localparam int unsigned W_PTR   = 2;
  localparam int unsigned W_PAIR0 = 3;
  localparam int unsigned N_PAIRS = 4;

endpackage

// File: rtl/mpu_addr_decode.sv
module mpu_addr_decode
  import mpu_regs_pkg::*;
(
  input  logic [3:0] idx,
  output reg_kind_e  kind
);

  localparam int unsigned LAST_W = W_PAIR0 + 2 * N_PAIRS - 1;

  always_comb begin
    kind = K_NONE;
    if (idx == 4'(W_GEOM))      kind = K_GEOM;
    else if (idx == 4'(W_CTRL)) kind = K_CTRL;
    else if (idx == 4'(W_PTR))  kind = K_PTR;
    else if (idx >= 4'(W_PAIR0) && idx <= 4'(LAST_W))
      kind = (idx[0] == 1'(W_PAIR0 & 1)) ? K_BASE : K_ATTR;
  end

endmodule

// File: rtl/mpu_region_bank.sv
module mpu_region_bank
  import mpu_regs_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 base_we,
  input  logic                 attr_we,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [31:BASE_LSB]   wr_base,
  input  logic [15:0]          wr_size,
  input  logic [15:0]          wr_attr,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [31:BASE_LSB]   rd_base,
  output logic [15:0]          rd_size,
  output logic [15:0]          rd_attr
);

  logic [31:BASE_LSB] base_q [NREG];
  logic [15:0]        size_q [NREG];
  logic [15:0]        attr_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic base_en, attr_en;
    assign base_en = base_we && (wr_idx == IDX_W'(g));
    assign attr_en = attr_we && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
      end else if (base_en) begin
        base_q[g] <= wr_base;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q[g] <= '0;
        attr_q[g] <= '0;
      end else if (attr_en) begin
        size_q[g] <= wr_size;
        attr_q[g] <= wr_attr;
      end
    end
  end

  always_comb begin
    rd_base = '0;
    rd_size = '0;
    rd_attr = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_base = base_q[i];
        rd_size = size_q[i];
        rd_attr = attr_q[i];
      end
    end
  end

endmodule

// File: rtl/mpu_reg_file.sv
module mpu_reg_file
  import mpu_regs_pkg::*;
#(
  parameter int unsigned NREG = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  reg_idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        inval,
  output logic        ctrl_illegal
);

  localparam logic [31:0] NREG_W    = 32'(NREG);
  localparam logic [31:0] GEOM_WORD = NREG_W << 8;

  reg_kind_e kind;

  logic [IDX_W-1:0]  ptr_q, ptr_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              inval_q, inval_d;
  logic              illegal_q, illegal_d;
  logic              base_we, attr_we;
  logic [IDX_W-1:0]  tgt_idx;
  logic              cur_ok, sel_ok;

  logic [31:BASE_LSB] rd_base;
  logic [15:0]        rd_size, rd_attr;

  mpu_addr_decode u_dec (
    .idx  (reg_idx),
    .kind (kind)
  );

  mpu_region_bank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .base_we (base_we),
    .attr_we (attr_we),
    .wr_idx  (tgt_idx),
    .wr_base (wdata[31:BASE_LSB]),
    .wr_size (wdata[15:0] & SIZE_MASK),
    .wr_attr (wdata[31:16] & ATTR_MASK),
    .rd_idx  (ptr_q),
    .rd_base (rd_base),
    .rd_size (rd_size),
    .rd_attr (rd_attr)
  );

  assign cur_ok = 32'(ptr_q) < NREG_W;
  assign sel_ok = 32'(wdata[IDX_W-1:0]) < NREG_W;

  // next-state
  always_comb begin
    ptr_d     = ptr_q;
    ctrl_d    = ctrl_q;
    inval_d   = 1'b0;
    illegal_d = 1'b0;
    base_we   = 1'b0;
    attr_we   = 1'b0;
    tgt_idx   = ptr_q;
    if (wr_en) begin
      unique case (kind)
        K_CTRL: begin
          ctrl_d    = wdata[CTRL_W-1:0];
          inval_d   = 1'b1;
          illegal_d = wdata[1] & ~wdata[0];
        end
        K_PTR: begin
          if (wdata < NREG_W) ptr_d = wdata[IDX_W-1:0];
        end
        K_BASE: begin
          if (wdata[SEL_BIT]) begin
            if (sel_ok) begin
              tgt_idx = wdata[IDX_W-1:0];
              ptr_d   = wdata[IDX_W-1:0];
              base_we = 1'b1;
              inval_d = 1'b1;
            end
          end else if (cur_ok) begin
            base_we = 1'b1;
            inval_d = 1'b1;
          end
        end
        K_ATTR: begin
          if (cur_ok) begin
            attr_we = 1'b1;
            inval_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      ctrl_q    <= '0;
      inval_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      ptr_q     <= ptr_d;
      ctrl_q    <= ctrl_d;
      inval_q   <= inval_d;
      illegal_q <= illegal_d;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    unique case (kind)
      K_GEOM: rdata = GEOM_WORD;
      K_CTRL: rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      K_PTR:  rdata = {{(32-IDX_W){1'b0}}, ptr_q};
      K_BASE: if (cur_ok) rdata = {rd_base, 1'b0, ptr_q};
      K_ATTR: if (cur_ok) rdata = {rd_attr, rd_size};
      default: rdata = '0;
    endcase
  end

  assign inval        = inval_q;
  assign ctrl_illegal = illegal_q;

  // checks
  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr_q) < NREG_W);

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_PTR && wdata >= NREG_W) |=> $stable(ptr_q));

  p_sel_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_BASE && wdata[SEL_BIT] && !sel_ok)
      |=> (!inval && $stable(ptr_q)));

  p_illegal_inval_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_illegal |-> inval);

  p_ctrl_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == K_CTRL) |=> inval);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !inval);

endmodule

// File: tb/mpu_reg_file_test.sv
`timescale 1ns/1ps
module mpu_reg_file_test;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  reg_idx;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        inval;
  logic        ctrl_illegal;

  int tests = 0;
  int fails = 0;

  // model state
  logic [31:0] m_base [16];
  logic [15:0] m_size [16];
  logic [15:0] m_attr [16];
  logic [3:0]  m_ptr;
  logic [2:0]  m_ctrl;

  always #5 clk = ~clk;

  mpu_reg_file #(.NREG(N)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rdata), .inval(inval), .ctrl_illegal(ctrl_illegal)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int w);
    if (w == 0) return 32'(N) << 8;
    if (w == 1) return {29'b0, m_ctrl};
    if (w == 2) return {28'b0, m_ptr};
    if (w >= 3 && w <= 10 && (w % 2) == 1) return m_base[m_ptr] | {28'b0, m_ptr};
    if (w >= 3 && w <= 10) return {m_attr[m_ptr], m_size[m_ptr]};
    return 32'b0;
  endfunction

  task automatic rd(input int w, input string req);
    @(negedge clk);
    reg_idx = 4'(w);
    #1;
    check(req, rdata, exp_read(w));
  endtask

  task automatic wr(input int w, input logic [31:0] d, input string req);
    logic ei, el;
    ei = 1'b0; el = 1'b0;
    @(negedge clk);
    wr_en = 1'b1; reg_idx = 4'(w); wdata = d;
    if (w == 1) begin
      m_ctrl = d[2:0]; ei = 1'b1; el = d[1] & ~d[0];
    end else if (w == 2) begin
      if (d < 32'(N)) m_ptr = d[3:0];
    end else if (w >= 3 && w <= 10 && (w % 2) == 1) begin
      if (d[4]) begin
        if (int'(d[3:0]) < N) begin
          m_ptr = d[3:0]; m_base[m_ptr] = d & 32'hFFFF_FFE0; ei = 1'b1;
        end
      end else begin
        m_base[m_ptr] = d & 32'hFFFF_FFE0; ei = 1'b1;
      end
    end else if (w >= 3 && w <= 10) begin
      m_size[m_ptr] = d[15:0] & 16'hFF3F;
      m_attr[m_ptr] = d[31:16] & 16'h173F;
      ei = 1'b1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    check({req, " inval R9"}, {31'b0, inval}, {31'b0, ei});
    check({req, " illegal R3"}, {31'b0, ctrl_illegal}, {31'b0, el});
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_base[i] = '0; m_size[i] = '0; m_attr[i] = '0;
    end
    m_ptr = '0; m_ctrl = '0;
    rst_n = 1'b0; wr_en = 1'b0; reg_idx = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 inval", {31'b0, inval}, 32'b0);
    check("R10 illegal", {31'b0, ctrl_illegal}, 32'b0);
    for (int w = 1; w <= 4; w++) rd(w, "R10 reset read");

    // R1 geometry word
    rd(0, "R1 geometry");
    wr(0, 32'hFFFF_FFFF, "R1 write");
    rd(0, "R1 geometry after write");

    // R2/R3 control sweep
    for (int v = 0; v < 8; v++) begin
      wr(1, 32'hDEAD_BEE8 | 32'(v), "R2 ctrl");
      rd(1, "R2 ctrl readback");
    end

    // R4 pointer sweep, including values above the count
    for (int v = 0; v < 16; v++) begin
      wr(2, 32'(v), "R4 ptr");
      rd(2, "R4 ptr readback");
    end
    wr(2, 32'h0000_0103, "R4 wide ptr");
    rd(2, "R4 wide ptr readback");

    // R5/R7/R8 indirect programming through each alias pair
    for (int r = 0; r < N; r++) begin
      int pair;
      pair = r % 4;
      wr(2, 32'(r), "R4 ptr set");
      wr(3 + 2 * pair, (32'h1357_9BDF * 32'(r + 1)) & 32'hFFFF_FFEF, "R5 R8 base");
      wr(4 + 2 * pair, 32'hFFFF_FFFF ^ (32'h0101_0101 * 32'(r)), "R7 R8 attr");
    end
    for (int r = 0; r < N; r++) begin
      wr(2, 32'(r), "R4 ptr set");
      for (int w = 3; w <= 10; w++) rd(w, "R5 R7 R8 readback");
    end

    // R6 select-bit base writes, in and out of range
    for (int v = 15; v >= 0; v--) begin
      wr(5, 32'hC000_0010 | (32'(v) << 20) | 32'(v), "R6 select base");
      rd(2, "R6 ptr after select");
      rd(3, "R6 base after select");
    end
    for (int r = 0; r < N; r++) begin
      wr(2, 32'(r), "R4 ptr set");
      rd(9, "R6 base sweep");
    end

    // R11 unmapped words
    for (int w = 11; w < 16; w++) begin
      wr(w, 32'hFFFF_FFFF, "R11 unmapped write");
      rd(w, "R11 unmapped read");
    end
    for (int w = 1; w <= 10; w++) rd(w, "R11 state intact");

    // R9 pulse lasts one cycle
    wr(1, 32'h1, "R9 ctrl");
    @(negedge clk);
    check("R9 pulse ends", {31'b0, inval}, 32'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule